// File: doc/BRIEF.md
# Recovery register read responder

This block answers register reads issued by a recovery initiator over a byte-serial target link. Before the repeated start, the initiator sends a short request of two bytes. The first byte selects the register. The second byte is a CRC-8 over the first. The block validates that checksum. If it matches, the block reads the selected register through a one-cycle-latency read port and holds the result as a pending response descriptor.

When the controller begins the read phase, the block streams a framed reply on a valid/ready byte interface. The reply is a two-byte length, then the register bytes, then a CRC-8 over everything already sent in that reply. A controller that ends the read early simply truncates the reply. A request whose checksum fails produces an error pulse and nothing else.

Top module: `rrsp_read_responder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tx_valid`, `desc_valid`, `pec_err` and `csr_rd_en` are low.
- R2: A request is a byte with `rx_first` high (the command), followed by the next `rx_valid` byte (the checksum). The checksum is CRC-8 with polynomial 0x07, initial value 0x00, processed MSB first, over the command byte. On a match, `csr_rd_en` is high for exactly the one cycle after the checksum byte is taken, with `csr_rd_addr` equal to the command.
- R3: On a checksum mismatch, `pec_err` pulses for the one cycle after the checksum byte, and no register read or descriptor follows.
- R4: `desc_valid` rises two cycles after a matching checksum byte is taken. It stays high until the read phase starts, `rd_stop` is seen, or a new command byte arrives.
- R5: A `rd_start` pulse while `desc_valid` is high raises `tx_valid` in the next cycle. The bytes then go out in this order: length low, length high, register bytes least significant first, checksum. `tx_last` is high only on the checksum byte.
- R6: The length field equals `csr_rd_len` clamped to MAX_BYTES (8 by default). It is sent as a 16-bit value, low byte first. A length of zero sends no data bytes.
- R7: The final byte is the CRC-8 (same polynomial as R2) over all earlier bytes of the same reply. The CRC restarts at zero for every reply.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R9: `rd_stop` during a reply drops `tx_valid` in the next cycle and discards the rest of the reply.
- R10: `rd_start` with no pending descriptor is ignored: `tx_valid` stays low.
- R11: A new command byte discards a pending descriptor. Bytes that arrive after the checksum byte and are not marked `rx_first` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received byte strobe |
| rx_first | input | 1 | Marks the command byte of a request |
| rx_data | input | 8 | Received byte |
| rd_start | input | 1 | Read phase begins after repeated start |
| rd_stop | input | 1 | Controller ended the transfer |
| csr_rd_en | output | 1 | Register read strobe |
| csr_rd_addr | output | 8 | Register selector (the command byte) |
| csr_rd_data | input | 8*MAX_BYTES | Register contents, valid the cycle after the strobe |
| csr_rd_len | input | clog2(MAX_BYTES+1) | Register size in bytes, valid with the data |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Reply checksum byte |
| tx_ready | input | 1 | Consumer accepts the reply byte |
| desc_valid | output | 1 | A response descriptor is pending |
| pec_err | output | 1 | Request checksum mismatch pulse |

## Verification
Requests are sent with correct and corrupted checksums. This separates the read-and-queue path from the error path, and confirms that a rejected request leaves a later read phase silent. Replies are drained both with ready held high and with random back-pressure, which exposes any byte loss or CRC drift under stalls. Register sizes of zero, a middle value, exactly the maximum and above the maximum exercise the length field and the clamp. Early stops, a new command displacing a pending reply, and two replies in a row test that framing state and the CRC restart cleanly.

// File: rtl/rrsp_pkg.sv
package rrsp_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HOLD = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    // One byte of CRC-8, polynomial x^8+x^2+x+1, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] r;
        r = crc ^ data;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rrsp_req_parser.sv
module rrsp_req_parser
    import rrsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid_i,
    input  logic       rx_first_i,
    input  logic [7:0] rx_data_i,
    output logic       ok_o,
    output logic       err_o,
    output logic [7:0] cmd_o
);

    typedef struct packed {
        logic       wait_pec;
        logic [7:0] cmd;
        logic [7:0] crc;
        logic       ok;
        logic       err;
    } parse_t;

    parse_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ok  = 1'b0;
        st_d.err = 1'b0;
        if (rx_valid_i) begin
            if (rx_first_i) begin
                st_d.wait_pec = 1'b1;
                st_d.cmd      = rx_data_i;
                st_d.crc      = crc8_step(8'h00, rx_data_i);
            end else if (st_q.wait_pec) begin
                st_d.wait_pec = 1'b0;
                if (rx_data_i == st_q.crc) st_d.ok  = 1'b1;
                else                       st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok_o  = st_q.ok;
    assign err_o = st_q.err;
    assign cmd_o = st_q.cmd;

    assert_ok_err_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_o, err_o}));

    assert_cmd_byte_no_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_first_i) |=> (!ok_o && !err_o));

endmodule

// File: rtl/rrsp_tx_framer.sv
module rrsp_tx_framer
    import rrsp_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int DATA_W   = 8 * MAX_BYTES,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1),
    localparam int IDX_W    = $clog2(MAX_BYTES + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic [DATA_W-1:0] csr_data_i,
    input  logic [LEN_W-1:0]  csr_len_i,
    input  logic              clear_i,
    input  logic              stop_i,
    input  logic              start_i,
    input  logic              tx_ready_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              tx_last_o,
    output logic              desc_valid_o
);

    typedef struct packed {
        tx_state_e         state;
        logic              fetch;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  len;
        logic [IDX_W-1:0]  idx;
        logic [7:0]        crc;
    } frame_t;

    frame_t st_d, st_q;

    logic [15:0]      len16;
    logic [IDX_W-1:0] last_idx;
    logic [LEN_W-1:0] len_clamped;
    logic [7:0]       cur_byte;

    always_comb begin
        len16       = 16'(st_q.len);
        last_idx    = IDX_W'(st_q.len) + IDX_W'(2);
        len_clamped = (csr_len_i > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : csr_len_i;

        if (st_q.idx == '0)                  cur_byte = len16[7:0];
        else if (st_q.idx == IDX_W'(1))      cur_byte = len16[15:8];
        else if (st_q.idx == last_idx)       cur_byte = st_q.crc;
        else begin
            cur_byte = 8'h00;
            for (int b = 0; b < MAX_BYTES; b++) begin
                if (st_q.idx == IDX_W'(b + 2)) cur_byte = st_q.data[8*b +: 8];
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.fetch = fetch_i;
        if (st_q.state == TX_SEND) begin
            if (stop_i) begin
                st_d.state = TX_IDLE;
            end else if (tx_ready_i) begin
                if (st_q.idx == last_idx) begin
                    st_d.state = TX_IDLE;
                end else begin
                    st_d.crc = crc8_step(st_q.crc, cur_byte);
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
        end else begin
            if (st_q.fetch) begin
                st_d.state = TX_HOLD;
                st_d.data  = csr_data_i;
                st_d.len   = len_clamped;
            end else if (clear_i || stop_i) begin
                st_d.state = TX_IDLE;
            end else if (st_q.state == TX_HOLD && start_i) begin
                st_d.state = TX_SEND;
                st_d.idx   = '0;
                st_d.crc   = 8'h00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= TX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid_o   = (st_q.state == TX_SEND);
    assign tx_data_o    = cur_byte;
    assign tx_last_o    = tx_valid_o && (st_q.idx == last_idx);
    assign desc_valid_o = (st_q.state == TX_HOLD);

    assert_stall_holds_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !stop_i) |=> (tx_valid_o && $stable(tx_data_o)));

    assert_stop_ends_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !tx_valid_o);

    assert_fetch_queues_desc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fetch && st_q.state != TX_SEND) |=> desc_valid_o);

    assert_start_without_desc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st_q.state == TX_IDLE) |=> !tx_valid_o);

endmodule

// File: rtl/rrsp_read_responder.sv
module rrsp_read_responder
    import rrsp_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int DATA_W   = 8 * MAX_BYTES,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [7:0]        rx_data,
    input  logic              rd_start,
    input  logic              rd_stop,
    output logic              csr_rd_en,
    output logic [7:0]        csr_rd_addr,
    input  logic [DATA_W-1:0] csr_rd_data,
    input  logic [LEN_W-1:0]  csr_rd_len,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              desc_valid,
    output logic              pec_err
);

    logic req_ok;
    logic [7:0] req_cmd;

    rrsp_req_parser u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid_i (rx_valid),
        .rx_first_i (rx_first),
        .rx_data_i  (rx_data),
        .ok_o       (req_ok),
        .err_o      (pec_err),
        .cmd_o      (req_cmd)
    );

    assign csr_rd_en   = req_ok;
    assign csr_rd_addr = req_cmd;

    rrsp_tx_framer #(.MAX_BYTES(MAX_BYTES)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_i      (req_ok),
        .csr_data_i   (csr_rd_data),
        .csr_len_i    (csr_rd_len),
        .clear_i      (rx_valid && rx_first),
        .stop_i       (rd_stop),
        .start_i      (rd_start),
        .tx_ready_i   (tx_ready),
        .tx_valid_o   (tx_valid),
        .tx_data_o    (tx_data),
        .tx_last_o    (tx_last),
        .desc_valid_o (desc_valid)
    );

    assert_last_only_when_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_error_blocks_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pec_err |-> !csr_rd_en);

endmodule

// File: tb/rrsp_read_responder_test.sv
module rrsp_read_responder_test;

    localparam int MAXB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_first = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rd_start = 1'b0, rd_stop = 1'b0;
    logic        csr_rd_en;
    logic [7:0]  csr_rd_addr;
    logic [63:0] csr_rd_data = '0;
    logic [3:0]  csr_rd_len = '0;
    logic        tx_valid, tx_last, tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        desc_valid, pec_err;

    int checks = 0, errors = 0;
    bit rdy_rand = 0;
    bit done = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    rrsp_read_responder #(.MAX_BYTES(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first), .rx_data(rx_data),
        .rd_start(rd_start), .rd_stop(rd_stop), .csr_rd_en(csr_rd_en), .csr_rd_addr(csr_rd_addr),
        .csr_rd_data(csr_rd_data), .csr_rd_len(csr_rd_len), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .desc_valid(desc_valid), .pec_err(pec_err)
    );

    function automatic bit [7:0] ref_crc(bit [7:0] c, bit [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            bit fb = c[7] ^ d[i];
            c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    function automatic bit [7:0] reg_byte(bit [7:0] cmd, int b);
        return 8'(cmd * 7 + b * 13 + 1);
    endfunction

    function automatic bit [63:0] reg_val(bit [7:0] cmd);
        bit [63:0] v = '0;
        for (int b = 0; b < 8; b++) v[8*b +: 8] = reg_byte(cmd, b);
        return v;
    endfunction

    // register file stand-in: one cycle read latency, size = low nibble of selector
    always @(posedge clk) begin
        if (csr_rd_en) begin
            csr_rd_data <= reg_val(csr_rd_addr);
            csr_rd_len  <= csr_rd_addr[3:0];
        end
    end

    // reference model
    int        m_state = 0;
    bit [7:0]  q[$];
    int        m_idx = 0;
    bit        m_wait = 0, m_ok = 0, m_err = 0, m_fetch = 0;
    bit [7:0]  m_cmd = 0, m_ok_cmd = 0, m_fetch_cmd = 0;

    always @(posedge clk) begin
        bit n_ok, n_err;
        n_ok = 0; n_err = 0;
        if (!rst_n) begin
            m_state = 0; m_idx = 0; m_wait = 0; m_ok = 0; m_err = 0; m_fetch = 0;
            q.delete();
        end else begin
            if (m_state == 2) begin
                if (rd_stop) m_state = 0;
                else if (tx_ready) begin
                    if (m_idx == q.size() - 1) m_state = 0;
                    else m_idx++;
                end
            end else begin
                if (m_fetch) begin
                    int n;
                    bit [7:0] c;
                    n = m_fetch_cmd[3:0];
                    if (n > MAXB) n = MAXB;
                    q.delete();
                    q.push_back(8'(n));
                    q.push_back(8'h00);
                    for (int b = 0; b < n; b++) q.push_back(reg_byte(m_fetch_cmd, b));
                    c = 8'h00;
                    foreach (q[k]) c = ref_crc(c, q[k]);
                    q.push_back(c);
                    m_state = 1;
                end else if ((rx_valid && rx_first) || rd_stop) m_state = 0;
                else if (m_state == 1 && rd_start) begin
                    m_state = 2; m_idx = 0;
                end
            end
            m_fetch = m_ok; m_fetch_cmd = m_ok_cmd;
            if (rx_valid) begin
                if (rx_first) begin m_wait = 1; m_cmd = rx_data; end
                else if (m_wait) begin
                    m_wait = 0;
                    if (rx_data == ref_crc(8'h00, m_cmd)) n_ok = 1; else n_err = 1;
                end
            end
            m_ok = n_ok; m_ok_cmd = m_cmd; m_err = n_err;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 csr_rd_en", 8'(csr_rd_en), 8'(m_ok));
            if (m_ok) check("R2 csr_rd_addr", csr_rd_addr, m_ok_cmd);
            check("R3 pec_err", 8'(pec_err), 8'(m_err));
            check("R4 desc_valid", 8'(desc_valid), 8'(m_state == 1));
            check("R5 tx_valid", 8'(tx_valid), 8'(m_state == 2));
            if (m_state == 2 && tx_valid) begin
                check(m_idx < 2 ? "R6 length byte" : (m_idx == q.size() - 1 ? "R7 checksum byte" : "R5 data byte"),
                      tx_data, q[m_idx]);
                check("R5 tx_last", 8'(tx_last), 8'(m_idx == q.size() - 1));
            end
        end
    end

    initial forever begin
        @(negedge clk);
        tx_ready = rdy_rand ? 1'($urandom_range(0, 1)) : 1'b1;
    end

    task automatic send_req(bit [7:0] cmd, bit good);
        @(negedge clk); rx_valid = 1; rx_first = 1; rx_data = cmd;
        @(negedge clk); rx_first = 0; rx_data = good ? ref_crc(8'h00, cmd) : (ref_crc(8'h00, cmd) ^ 8'h5A);
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); rd_start = 1;
        @(negedge clk); rd_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); rd_stop = 1;
        @(negedge clk); rd_stop = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        phase = "R1";
        check("R1 tx_valid in reset", 8'(tx_valid), 8'h00);
        check("R1 desc_valid in reset", 8'(desc_valid), 8'h00);
        check("R1 pec_err in reset", 8'(pec_err), 8'h00);
        check("R1 csr_rd_en in reset", 8'(csr_rd_en), 8'h00);
        rst_n = 1;
        @(negedge clk);
        check("R1 tx_valid after reset", 8'(tx_valid), 8'h00);

        phase = "R2 R5 basic";   send_req(8'h14, 1); idle(2); pulse_start(); idle(12);
        phase = "R3 bad checksum"; send_req(8'h35, 0); idle(3);
        phase = "R10 start idle"; pulse_start(); idle(4);
        phase = "R6 clamp R8 stall"; rdy_rand = 1; send_req(8'h1C, 1); idle(2); pulse_start(); idle(40);
        phase = "R6 full size"; send_req(8'h08, 1); idle(2); pulse_start(); idle(40); rdy_rand = 0;
        phase = "R6 zero length"; send_req(8'h10, 1); idle(2); pulse_start(); idle(6);
        phase = "R9 early stop"; send_req(8'h17, 1); idle(2); pulse_start(); idle(2); pulse_stop(); idle(4);
        phase = "R9 start after stop"; pulse_start(); idle(4);
        phase = "R11 new command"; send_req(8'h15, 1); idle(2);
        @(negedge clk); rx_valid = 1; rx_first = 1; rx_data = 8'h22;
        @(negedge clk); rx_valid = 0; rx_first = 0;
        idle(2); pulse_start(); idle(4);
        phase = "R11 trailing byte"; send_req(8'h13, 1);
        @(negedge clk); rx_valid = 1; rx_data = 8'hAA;
        @(negedge clk); rx_valid = 0;
        pulse_start(); idle(10);
        phase = "R7 back to back"; send_req(8'h12, 1); idle(2); pulse_start(); idle(8);
        send_req(8'h12, 1); idle(2); pulse_start(); idle(8);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule